// File: doc/BRIEF.md
# Twisted-Ring Strobe Sequencer

This block drives a set of downstream units in turn. It holds a twisted-ring (Johnson) counter of `STAGES` flip-flops. The counter steps on every rising clock edge and passes through `2*STAGES` states before it repeats. Each state is turned into one of `2*STAGES` strobe lines by a two-input AND gate. Exactly one strobe is high in any cycle, and the high line moves up by one position on each clock.

A synchronous active-low reset puts every stage at zero, which selects strobe 0. A consumer connects one unit to each strobe line. The raw stage values are also brought out so that a neighbour can decode coarser phases from them. The design assumes the counter only ever holds the states it reaches from reset. It does not recover from any other state.

Top module: `johnson_strobe_gen`

## Requirements
- R1: On a rising clock edge with `rst_n` low, every bit of `stage_q` becomes 0 and `strobe` becomes the pattern with only bit 0 set. This holds for as long as `rst_n` stays low.
- R2: On each rising edge with `rst_n` high, `stage_q[0]` takes the inverse of the value `stage_q[STAGES-1]` held before that edge.
- R3: On each rising edge with `rst_n` high, each `stage_q[i]` with i ≥ 1 takes the value `stage_q[i-1]` held before that edge.
- R4: After reset, the counter visits `2*STAGES` distinct states and then returns to the first one.
- R5: While `rst_n` has been high since a reset edge, exactly one bit of `strobe` is 1 in every cycle.
- R6: The index of the high strobe bit goes up by one on each clock edge with `rst_n` high, and goes from `2*STAGES-1` back to 0.
- R7: Strobe index k marks a fixed state, counted in edges since reset. For k ≤ STAGES, stages 0..k-1 hold 1 and the rest hold 0. For k > STAGES, stages 0..k-STAGES-1 hold 0 and the rest hold 1.
- R8: With STAGES=3, and with `stage_q` read as the integer {stage 2, stage 1, stage 0}, the values after reset run 0, 1, 3, 7, 6, 4 and then repeat.
- R9: A reset applied in the middle of a run returns the block to strobe 0 and an all-zero `stage_q` at the next edge. Counting then starts again from index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stages update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_q | output | STAGES | Raw counter stages; bit 0 is the stage fed by the inverted last stage |
| strobe | output | 2*STAGES | One-hot timing lines; bit k is high in phase k |

## Verification
The bench builds three copies of the block side by side, with STAGES set to 2, 3 and 4. The 2-stage copy exercises a decoder with a single middle term on each side. The 4-stage copy has several adjacent-pair terms, which shows that the decode pattern scales with the parameter. The 3-stage copy is also compared against a fixed list of counter values. All three copies share the reset pulses, so the cases where a wrap and a mid-run reset fall in different phases are covered.

// File: rtl/johnson_pkg.sv
// Package: shared sizing helpers for the twisted-ring strobe sequencer.
// Assumes the stage count is at least 1.
package johnson_pkg;

    // Number of distinct phases produced by a twisted ring of n stages.
    function automatic int phase_count(input int n);
        return 2 * n;
    endfunction

endpackage

// File: rtl/johnson_ring.sv
// Module: twisted-ring counter core.
// The first stage loads the inverse of the last stage. Every later stage loads
// its lower neighbour. A synchronous active-low reset clears all stages.
// Assumes only states reachable from reset ever occur.
module johnson_ring #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] ring_q
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] ring_next;

    // Next-state logic: the ring shifts up and the inverted top bit feeds back.
    always_comb begin
        ring_next[0] = ~ring_q[LAST];
        for (int i = 1; i < STAGES; i++) begin
            ring_next[i] = ring_q[i-1];
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_next;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (ring_q == '0)); // R1

    AST_FEEDBACK_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ring_q[0] == ~$past(ring_q[LAST]))); // R2

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_shift_chk
            AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (ring_q[g] == $past(ring_q[g-1]))); // R3
        end
    endgenerate

endmodule

// File: rtl/johnson_decode.sv
// Module: two-input AND decoder from the ring stages to the one-hot strobes.
// The all-zero and all-one phases use the first and last stages. Every other
// phase uses the adjacent pair at the edge between its ones and its zeros.
// Assumes the ring holds a legal twisted-ring state.
module johnson_decode #(
    parameter int STAGES = 3
) (
    input  logic [STAGES-1:0]   ring_q,
    output logic [2*STAGES-1:0] phase_hot
);

    localparam int LAST = STAGES - 1;

    // End phases: all stages clear (phase 0) and all stages set (phase STAGES).
    assign phase_hot[0]      = ~ring_q[0] & ~ring_q[LAST];
    assign phase_hot[STAGES] =  ring_q[0] &  ring_q[LAST];

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_pair
            // Filling half: ones reach up to stage k-1.
            assign phase_hot[k]          =  ring_q[k-1] & ~ring_q[k];
            // Draining half: zeros reach up to stage k-1.
            assign phase_hot[STAGES + k] = ~ring_q[k-1] &  ring_q[k];
        end
    endgenerate

endmodule

// File: rtl/johnson_strobe_gen.sv
// Module: top of the twisted-ring strobe sequencer.
// Connects the ring counter to the pair decoder. Brings out the raw stages
// and the 2*STAGES one-hot strobes. The reset is synchronous and active low.
// Assumes STAGES >= 1.
module johnson_strobe_gen
    import johnson_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [STAGES-1:0]   stage_q,
    output logic [2*STAGES-1:0] strobe
);

    localparam int PHASES = phase_count(STAGES);

    logic [STAGES-1:0] ring_q;
    logic [PHASES-1:0] phase_hot;

    johnson_ring #(.STAGES(STAGES)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .ring_q (ring_q)
    );

    johnson_decode #(.STAGES(STAGES)) u_decode (
        .ring_q    (ring_q),
        .phase_hot (phase_hot)
    );

    // Output wiring.
    assign stage_q = ring_q;
    assign strobe  = phase_hot;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot(strobe)); // R5

    AST_STROBE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (strobe == {$past(strobe[PHASES-2:0]), $past(strobe[PHASES-1])})); // R6

    AST_RESET_PHASE0: assert property (@(posedge clk) !rst_n |=> (strobe == PHASES'(1))); // R9

endmodule

// File: tb/test_johnson_strobe_gen.sv
// Bench: three copies of the sequencer (STAGES = 2, 3, 4) with a behavioural
// phase-index model for each, compared on every falling clock edge.
module test_johnson_strobe_gen;

    localparam int CLK_PERIOD = 10;
    localparam int COPIES     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Records one check and prints a FAIL line on a mismatch.
    task automatic check(input bit ok, input string req, input int n, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (STAGES=%0d) actual=%0d expected=%0d at %0t", req, n, act, exp, $time);
        end
    endtask

    // Expected stage vector for phase k of an n-stage twisted ring.
    function automatic logic [7:0] ring_state(input int n, input int k);
        logic [7:0] v = '0;
        for (int i = 0; i < n; i++) begin
            if (k <= n) v[i] = (i < k);
            else        v[i] = (i >= k - n);
        end
        return v;
    endfunction

    generate
        for (genvar c = 0; c < COPIES; c++) begin : g_copy
            localparam int NS = c + 2;
            localparam int NP = 2 * NS;

            logic [NS-1:0] stage_q;
            logic [NP-1:0] strobe;

            johnson_strobe_gen #(.STAGES(NS)) i_johnson_strobe_gen (
                .clk     (clk),
                .rst_n   (rst_n),
                .stage_q (stage_q),
                .strobe  (strobe)
            );

            int         idx = 0;
            bit         started = 1'b0;
            bit         in_rst = 1'b1;
            bit         have_prev = 1'b0;
            logic [7:0] prev_q = '0;
            logic [7:0] lap[$];
            int         seq3[$] = '{0, 1, 3, 7, 6, 4};

            // Behavioural model: the phase index counts edges since reset.
            always @(posedge clk) begin
                started = 1'b1;
                in_rst  = !rst_n;
                if (!rst_n) idx = 0;
                else        idx = (idx + 1) % NP;
            end

            // Comparison away from the active edge.
            always @(negedge clk) begin
                if (started && !done) begin
                    if (in_rst) begin
                        check(stage_q == '0, "R1", NS, int'(stage_q), 0);
                        check(strobe == NP'(1), "R9", NS, int'(strobe), 1);
                        have_prev = 1'b0;
                        lap.delete();
                    end else begin
                        check($countones(strobe) == 1, "R5", NS, $countones(strobe), 1);
                        check(strobe == (NP'(1) << idx), "R6", NS, int'(strobe), int'(NP'(1) << idx));
                        check(8'(stage_q) == ring_state(NS, idx), "R7", NS, int'(stage_q), int'(ring_state(NS, idx)));
                        if (have_prev) begin
                            check(stage_q[0] == ~prev_q[NS-1], "R2", NS, int'(stage_q[0]), int'(~prev_q[NS-1]));
                            for (int i = 1; i < NS; i++) begin
                                check(stage_q[i] == prev_q[i-1], "R3", NS, int'(stage_q[i]), int'(prev_q[i-1]));
                            end
                        end
                        if (NS == 3) begin
                            check(int'(stage_q) == seq3[idx], "R8", NS, int'(stage_q), seq3[idx]);
                        end
                        lap.push_back(8'(stage_q));
                        if (lap.size() == NP + 1) begin
                            int dup = 0;
                            for (int a = 0; a < NP; a++) begin
                                for (int b = a + 1; b < NP; b++) begin
                                    if (lap[a] == lap[b]) dup++;
                                end
                            end
                            check(dup == 0, "R4", NS, dup, 0);
                            check(lap[NP] == lap[0], "R4", NS, int'(lap[NP]), int'(lap[0]));
                            lap.delete();
                            lap.push_back(8'(stage_q));
                        end
                        have_prev = 1'b1;
                    end
                    prev_q = 8'(stage_q);
                end
            end
        end
    endgenerate

    // Stimulus: initial reset, a long run, a mid-run reset, a second run.
    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (29) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (25) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        done = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule